// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block guards a five-stage in-order pipeline against the one data hazard that operand forwarding cannot close: a load word (LW) whose destination register is read by the very next instruction. It watches the instruction currently decoding (the IF/ID word) against the instruction it owns in the ID/EX instruction register. When a true load-use dependence is present, it raises `stall` so that the surrounding pipeline holds the PC and IF/ID. It also loads the fixed no-op word into ID/EX, which opens a one-cycle gap. After that gap the dependent instruction moves on and takes the loaded value from the MEM/WB forwarding path.

The ID/EX instruction field is kept inside the block because it is the only place a bubble is written. With no stall and no flush, it takes the IF/ID word on every clock. A branch-misprediction flush input takes priority over the stall: the stall is held low and the ID/EX field is loaded with the no-op word.

Instruction fields as seen by this block: opcode in bits 16:14, first source register (regA) in bits 13:11, second register (regB) in bits 10:8. Opcodes: ADD=0, NAND=1, LW=2, SW=3, BEQ=4, 5 unused, HALT=6, NOOP=7. The no-op word is 0x1c000 (opcode 7, all other bits zero).

Top module: `luh_stall_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `idex_instr` holds the no-op word 0x1c000 (opcode 7 in bits 16:14, all other bits zero), and `stall` is low until a dependence appears.
- R2: `stall` is high in the same cycle when the ID/EX opcode (bits 16:14) is LW (2), its regB field (bits 10:8) equals the IF/ID regA field (bits 13:11), the IF/ID opcode is ADD (0), NAND (1), LW (2), SW (3) or BEQ (4), and `flush` is low.
- R3: `stall` is high when the ID/EX instruction is LW and its regB equals the IF/ID regB field, but only if the IF/ID opcode is ADD, NAND, SW or BEQ; the regB field of an IF/ID LW never causes a stall.
- R4: An IF/ID instruction with opcode HALT (6), NOOP (7) or the unused code 5 never causes a stall, whatever its register fields hold.
- R5: No stall is raised when the ID/EX opcode is anything other than LW, and the regA field of an ID/EX LW (its base register) is never treated as its destination.
- R6: In a stall cycle `bubble` is high and, at the next rising edge, `idex_instr` becomes the no-op word 0x1c000.
- R7: A stall lasts exactly one cycle: with IF/ID held during the stall, `stall` is low in the following cycle and the held instruction enters ID/EX one edge later.
- R8: When `flush` is high, `stall` is low, `bubble` is high, and `idex_instr` becomes the no-op word at the next edge, even if a load-use dependence is present.
- R9: When neither a stall nor a flush is present, `bubble` is low and `idex_instr` takes the IF/ID word at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ifid_instr | input | 32 | Instruction word in IF/ID (the one being decoded) |
| flush | input | 1 | Branch-misprediction flush, overrides the stall |
| stall | output | 1 | Hold PC and IF/ID this cycle |
| bubble | output | 1 | A no-op word is written into ID/EX at this edge |
| idex_instr | output | 32 | Instruction field of the ID/EX register |

## Verification
The producer-consumer pairs cross every consumer opcode with a match on regA only, regB only and neither, so a wrong source-usage table shows up as a spurious or missing stall on a specific opcode. Pairs whose producer is not a load, or whose match lies on the load's base field, separate a detector that compares the right fields from one that compares any register. A flush on a dependent pair separates the priority rule, and a held dependent instruction, plus a chain of two dependent loads, separate a single-cycle stall from a repeating or missing one.

// File: rtl/luh_pkg.sv
// Package: shared opcode encoding and field widths for the load-use stall unit.
// Assumes a 3-bit opcode and 3-bit register specifiers.
package luh_pkg;

    localparam int OPC_W = 3;
    localparam int REG_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_RSV  = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } luh_op_e;

    typedef logic [REG_W-1:0] luh_reg_t;

endpackage

// File: rtl/luh_read_decode.sv
// Module: luh_read_decode
// Says which register fields an instruction reads as operands.
// Assumes: ALU ops, stores and branches read both fields; a load reads only
// its base field; halt, no-op and the unused code read nothing.
module luh_read_decode
    import luh_pkg::*;
(
    input  logic [OPC_W-1:0] op_bits,
    output logic             reads_a,
    output logic             reads_b
);

    luh_op_e op;

    // Purpose: map the raw opcode bits onto the shared enum.
    always_comb begin
        op = luh_op_e'(op_bits);
    end

    // Purpose: per-opcode source-usage table.
    always_comb begin
        reads_a = 1'b0;
        reads_b = 1'b0;
        case (op)
            OP_ADD, OP_NAND, OP_SW, OP_BEQ: begin
                reads_a = 1'b1;
                reads_b = 1'b1;
            end
            OP_LW: begin
                reads_a = 1'b1;
            end
            default: begin
                reads_a = 1'b0;
                reads_b = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/luh_dep_compare.sv
// Module: luh_dep_compare
// Compares one pending destination register against NUM_SRC source operands.
// Assumes: a source counts only when its use flag is set; the destination
// counts only when dest_valid is set.
module luh_dep_compare
    import luh_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic                   dest_valid,
    input  luh_reg_t               dest_reg,
    input  logic     [NUM_SRC-1:0] src_used,
    input  luh_reg_t [NUM_SRC-1:0] src_reg,
    output logic                   hit
);

    logic [NUM_SRC-1:0] match;

    // One comparator per source operand.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Purpose: flag a used source that names the pending destination.
        always_comb begin
            match[g] = src_used[g] && (src_reg[g] == dest_reg);
        end
    end

    // Purpose: any matching source is a dependence on a valid destination.
    always_comb begin
        hit = dest_valid && (|match);
    end

endmodule

// File: rtl/luh_stall_unit.sv
// Module: luh_stall_unit (top)
// Detects a load followed at once by a reader of the loaded register, raises
// a one-cycle stall and writes the no-op word into its ID/EX instruction
// register. A flush overrides the stall and also writes the no-op word.
// Assumes: the surrounding pipeline holds PC and IF/ID while stall is high;
// the load's destination is its regB field.
module luh_stall_unit
    import luh_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OPC_LSB = 14,
    parameter int RA_LSB  = 11,
    parameter int RB_LSB  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] ifid_instr,
    input  logic               flush,
    output logic               stall,
    output logic               bubble,
    output logic [INSTR_W-1:0] idex_instr
);

    localparam int NUM_SRC = 2;
    localparam logic [INSTR_W-1:0] NOP_WORD =
        INSTR_W'(int'(OP_NOOP)) << OPC_LSB;

    logic [INSTR_W-1:0]     idex_q;
    logic [OPC_W-1:0]       idex_op;
    luh_reg_t               idex_dest;
    logic                   idex_is_load;
    logic [OPC_W-1:0]       ifid_op;
    logic                   ifid_reads_a;
    logic                   ifid_reads_b;
    logic [NUM_SRC-1:0]     src_used;
    luh_reg_t [NUM_SRC-1:0] src_reg;
    logic                   dep_hit;

    // Purpose: slice the fields this unit looks at.
    always_comb begin
        idex_op   = idex_q[OPC_LSB +: OPC_W];
        idex_dest = idex_q[RB_LSB +: REG_W];
        ifid_op   = ifid_instr[OPC_LSB +: OPC_W];
        src_reg[0] = ifid_instr[RA_LSB +: REG_W];
        src_reg[1] = ifid_instr[RB_LSB +: REG_W];
    end

    // Purpose: only a load in ID/EX has a destination that forwarding misses.
    always_comb begin
        idex_is_load = (luh_op_e'(idex_op) == OP_LW);
    end

    luh_read_decode u_decode (
        .op_bits (ifid_op),
        .reads_a (ifid_reads_a),
        .reads_b (ifid_reads_b)
    );

    // Purpose: pack the source-use flags in the same order as src_reg.
    always_comb begin
        src_used = {ifid_reads_b, ifid_reads_a};
    end

    luh_dep_compare #(
        .NUM_SRC (NUM_SRC)
    ) u_compare (
        .dest_valid (idex_is_load),
        .dest_reg   (idex_dest),
        .src_used   (src_used),
        .src_reg    (src_reg),
        .hit        (dep_hit)
    );

    // Purpose: flush wins over the stall; either one inserts a no-op.
    always_comb begin
        stall  = dep_hit && !flush;
        bubble = dep_hit || flush;
    end

    // Purpose: ID/EX instruction register with no-op insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_q <= NOP_WORD;
        end else if (bubble) begin
            idex_q <= NOP_WORD;
        end else begin
            idex_q <= ifid_instr;
        end
    end

    assign idex_instr = idex_q;

endmodule

// File: rtl/luh_stall_unit_chk.sv
// Module: luh_stall_unit_chk
// Property checker for luh_stall_unit, attached by the bind below.
// Assumes the same field positions as the checked instance.
module luh_stall_unit_chk
    import luh_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OPC_LSB = 14,
    parameter int RA_LSB  = 11,
    parameter int RB_LSB  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] ifid_instr,
    input logic               flush,
    input logic               stall,
    input logic               bubble,
    input logic [INSTR_W-1:0] idex_instr
);

    localparam logic [INSTR_W-1:0] NOP_WORD =
        INSTR_W'(int'(OP_NOOP)) << OPC_LSB;

    logic started;

    // Purpose: gate properties until one edge after reset has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b1;
    end

    AST_RESET_NOP: assert property (@(posedge clk)
        !rst_n |=> (idex_instr == NOP_WORD)); // R1

    AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (idex_instr[OPC_LSB +: OPC_W] == OP_LW)); // R5

    AST_QUIET_CONSUMER: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ifid_instr[OPC_LSB +: OPC_W] <= OP_BEQ)); // R4

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> bubble); // R6

    AST_BUBBLE_NOP: assert property (@(posedge clk) disable iff (!rst_n || !started)
        bubble |=> (idex_instr == NOP_WORD)); // R6

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !started)
        stall |=> !stall); // R7

    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!stall && bubble)); // R8

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n || !started)
        !bubble |=> (idex_instr == $past(ifid_instr))); // R9

endmodule

bind luh_stall_unit luh_stall_unit_chk #(
    .INSTR_W (INSTR_W),
    .OPC_LSB (OPC_LSB),
    .RA_LSB  (RA_LSB),
    .RB_LSB  (RB_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ifid_instr (ifid_instr),
    .flush      (flush),
    .stall      (stall),
    .bubble     (bubble),
    .idex_instr (idex_instr)
);

// File: tb/sim_luh_stall_unit.sv
// Bench for luh_stall_unit: a vector table of producer/consumer pairs walked
// by one loop, then directed tests for reset, stall length and chains.
module sim_luh_stall_unit;

    localparam int W = 32;
    localparam logic [W-1:0] NOP = 32'h0001_c000;
    localparam int NV = 16;

    // Entry: {opP, raP, rbP, opC, raC, rbC, flush, exp_stall}
    localparam logic [19:0] VEC [NV] = '{
        {3'd2,3'd0,3'd1, 3'd0,3'd1,3'd2, 1'b0,1'b1}, // R2 ADD regA
        {3'd2,3'd0,3'd3, 3'd0,3'd2,3'd3, 1'b0,1'b1}, // R3 ADD regB
        {3'd2,3'd0,3'd3, 3'd0,3'd4,3'd5, 1'b0,1'b0}, // R2 no match
        {3'd2,3'd1,3'd2, 3'd2,3'd2,3'd6, 1'b0,1'b1}, // R2 LW base
        {3'd2,3'd1,3'd2, 3'd2,3'd6,3'd2, 1'b0,1'b0}, // R3 LW regB not read
        {3'd2,3'd0,3'd4, 3'd3,3'd0,3'd4, 1'b0,1'b1}, // R3 SW data
        {3'd2,3'd0,3'd4, 3'd4,3'd4,3'd0, 1'b0,1'b1}, // R2 BEQ regA
        {3'd2,3'd0,3'd5, 3'd1,3'd1,3'd5, 1'b0,1'b1}, // R3 NAND regB
        {3'd2,3'd0,3'd5, 3'd6,3'd5,3'd5, 1'b0,1'b0}, // R4 HALT
        {3'd2,3'd0,3'd5, 3'd7,3'd5,3'd5, 1'b0,1'b0}, // R4 NOOP
        {3'd2,3'd0,3'd1, 3'd5,3'd1,3'd1, 1'b0,1'b0}, // R4 unused code
        {3'd0,3'd0,3'd2, 3'd0,3'd2,3'd2, 1'b0,1'b0}, // R5 ADD producer
        {3'd3,3'd0,3'd3, 3'd0,3'd3,3'd3, 1'b0,1'b0}, // R5 SW producer
        {3'd2,3'd3,3'd0, 3'd0,3'd3,3'd1, 1'b0,1'b0}, // R5 LW base not dest
        {3'd2,3'd0,3'd1, 3'd0,3'd1,3'd2, 1'b1,1'b0}, // R8 flush wins
        {3'd2,3'd0,3'd0, 3'd4,3'd0,3'd0, 1'b0,1'b1}  // R2 register zero
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] ifid_instr;
    logic         flush;
    logic         stall;
    logic         bubble;
    logic [W-1:0] idex_instr;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    luh_stall_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ifid_instr (ifid_instr),
        .flush      (flush),
        .stall      (stall),
        .bubble     (bubble),
        .idex_instr (idex_instr)
    );

    function automatic logic [W-1:0] mk(input logic [2:0] op,
                                        input logic [2:0] ra,
                                        input logic [2:0] rb);
        return (W'(op) << 14) | (W'(ra) << 11) | (W'(rb) << 8) | W'(8'h3c);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, let the rising edge pass, sample 1 ns later.
    task automatic drive(input logic [W-1:0] w, input logic f);
        @(negedge clk);
        ifid_instr = w;
        flush = f;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ifid_instr = mk(3'd2, 3'd0, 3'd1);
        flush = 1'b0;
        tick();
        tick();
        chk("R1 reset idex", idex_instr, NOP);
        drive(mk(3'd0, 3'd1, 3'd1), 1'b0);
        #1;
        chk("R1 reset stall", W'(stall), W'(0));
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] prod;
            logic [W-1:0] cons;
            logic         f;
            logic         es;
            prod = mk(VEC[i][19:17], VEC[i][16:14], VEC[i][13:11]);
            cons = mk(VEC[i][10:8], VEC[i][7:5], VEC[i][4:2]);
            f    = VEC[i][1];
            es   = VEC[i][0];
            drive(NOP, 1'b0);
            tick();
            drive(prod, 1'b0);
            tick();
            drive(cons, f);
            #1;
            chk($sformatf("R2/R3 vec%0d stall", i), W'(stall), W'(es));
            chk($sformatf("R6/R8/R9 vec%0d bubble", i), W'(bubble), W'(es | f));
            tick();
            chk($sformatf("R6/R8/R9 vec%0d idex", i), idex_instr,
                (es | f) ? NOP : cons);
        end

        // R7: dependent instruction held in IF/ID for one stall cycle only.
        drive(NOP, 1'b0);
        tick();
        drive(mk(3'd2, 3'd0, 3'd6), 1'b0);
        tick();
        drive(mk(3'd0, 3'd6, 3'd0), 1'b0);
        #1;
        chk("R7 first cycle stall", W'(stall), W'(1));
        tick();
        chk("R6 bubble in idex", idex_instr, NOP);
        #1;
        chk("R7 second cycle no stall", W'(stall), W'(0));
        tick();
        chk("R7 held instr enters", idex_instr, mk(3'd0, 3'd6, 3'd0));

        // R7 chain: LW r1 -> LW from base r1 into r2 -> ADD reads r2.
        drive(mk(3'd2, 3'd0, 3'd1), 1'b0);
        tick();
        drive(mk(3'd2, 3'd1, 3'd2), 1'b0);
        #1;
        chk("R2 chain first stall", W'(stall), W'(1));
        tick();
        #1;
        chk("R7 chain release", W'(stall), W'(0));
        tick();
        chk("R9 chain second load", idex_instr, mk(3'd2, 3'd1, 3'd2));
        drive(mk(3'd0, 3'd2, 3'd3), 1'b0);
        #1;
        chk("R2 chain second stall", W'(stall), W'(1));
        tick();
        #1;
        chk("R7 chain second release", W'(stall), W'(0));

        // R1: reset mid-run clears a pending load.
        drive(mk(3'd2, 3'd0, 3'd4), 1'b0);
        tick();
        rst_n = 1'b0;
        tick();
        chk("R1 mid-run reset idex", idex_instr, NOP);
        rst_n = 1'b1;
        drive(mk(3'd0, 3'd4, 3'd4), 1'b0);
        #1;
        chk("R1 no stall after reset", W'(stall), W'(0));
        tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule